// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter

This block keeps the current byte address of a serial memory's array between bus transactions. The protocol engine loads it when the two address bytes have been received. It steps the address after every data byte that moves, and the wrap rule depends on the direction of the transfer. During a write, only the offset inside a 32-byte page moves, so a long write burst wraps back to the start of the same page. During a read, the whole address moves, so a long read burst runs through the end of memory and continues at location zero.

The registered output gives the array read address and the write-buffer or array write address. After a transfer it holds the address of the last byte accessed plus one, and that value is where the next current-address read starts. Address decoding and bus sequencing are done by the surrounding logic.

Top module: `word_addr_ctr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `cur_addr` becomes 0 after that edge. Reset is synchronous and overrides every strobe.
- R2: When `load_strobe` is high at an edge, `cur_addr` becomes `load_word[12:0]` after that edge. Bits [15:13] of `load_word` (the three top bits of the first address byte) have no effect.
- R3: When `wr_step` is high and `load_strobe` is low at an edge, bits [4:0] of `cur_addr` increase by one modulo 32 and bits [12:5] keep their value. Offset 31 wraps to offset 0 of the same page.
- R4: When `rd_step` is high and both `wr_step` and `load_strobe` are low at an edge, the full 13-bit `cur_addr` increases by one modulo 8192. This carries across page boundaries, and 8191 wraps to 0.
- R5: When no strobe is high, `cur_addr` holds its value over any number of cycles.
- R6: When `load_strobe` is high together with `rd_step` or `wr_step` or both, the load wins and both steps are ignored.
- R7: When `rd_step` and `wr_step` are high together and `load_strobe` is low, the page-wrapping write rule of R3 applies once.
- R8: Every change to `cur_addr` appears one clock edge after the strobe that causes it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_strobe | input | 1 | Load the address from `load_word` |
| load_word | input | 16 | Two received address bytes, first byte in [15:8] |
| rd_step | input | 1 | One byte was read; step across the whole array |
| wr_step | input | 1 | One byte was written; step within the page |
| cur_addr | output | 13 | Current word address |

## Verification
The load and the two step strobes can all arrive in the same cycle, and the two step strobes can also arrive together. The bench raises the load strobe on the same edge as one or both steps, using a load value far from the current address, and expects the loaded value exactly with no increment applied. It also raises both steps together at page offset 31 with the top bits nonzero. It expects the page-wrapped result there, and a full increment would give a different one.

// File: rtl/wac_pkg.sv
// Package: shared action encoding for the word address counter.
// Assumes: consumed by all wac_* modules and the top.
package wac_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_PAGE  = 2'd2,
        ACT_LINE  = 2'd3
    } wac_act_e;
endpackage

// File: rtl/wac_prio.sv
// Module: wac_prio
// Resolves the three strobes into one action. The priority is load, then
// page step, then linear step. Assumes the strobes are synchronous to the
// counter clock.
module wac_prio
    import wac_pkg::*;
(
    input  logic     load_strobe,
    input  logic     rd_step,
    input  logic     wr_step,
    output wac_act_e act
);
    // Purpose: priority selection of the next-address action.
    always_comb begin
        if (load_strobe)  act = ACT_LOAD;
        else if (wr_step) act = ACT_PAGE;
        else if (rd_step) act = ACT_LINE;
        else              act = ACT_HOLD;
    end
endmodule

// File: rtl/wac_page_inc.sv
// Module: wac_page_inc
// Increments only the in-page offset field and leaves the page number as it
// is. Assumes PAGE_W <= ADDR_W. When the two are equal, the whole address is
// one page.
module wac_page_inc #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic [ADDR_W-1:0] a_in,
    output logic [ADDR_W-1:0] a_out
);
    localparam logic [PAGE_W-1:0] OFS_ONE = PAGE_W'(1);

    generate
        if (PAGE_W < ADDR_W) begin : g_split
            // Purpose: step the offset field; the page field passes through.
            always_comb a_out = {a_in[ADDR_W-1:PAGE_W], a_in[PAGE_W-1:0] + OFS_ONE};
        end else begin : g_whole
            // Purpose: the page covers the whole address, so step it all.
            always_comb a_out = a_in + OFS_ONE;
        end
    endgenerate
endmodule

// File: rtl/wac_line_inc.sv
// Module: wac_line_inc
// Increments the full address and wraps from the top location to zero.
// Assumes the array size is a power of two, 2**ADDR_W.
module wac_line_inc #(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] a_in,
    output logic [ADDR_W-1:0] a_out
);
    localparam logic [ADDR_W-1:0] ADR_ONE = ADDR_W'(1);

    // Purpose: modulo-2**ADDR_W increment.
    always_comb a_out = a_in + ADR_ONE;
endmodule

// File: rtl/word_addr_ctr.sv
// Module: word_addr_ctr
// Holds the current word address between transactions. A load takes the low
// ADDR_W bits of the two received address bytes. A write step wraps inside
// the page, and a read step wraps across the whole array. Assumes
// LOAD_W >= ADDR_W and a synchronous active-low reset.
module word_addr_ctr
    import wac_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5,
    parameter int LOAD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_strobe,
    input  logic [LOAD_W-1:0] load_word,
    input  logic              rd_step,
    input  logic              wr_step,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int HI_W = LOAD_W - ADDR_W;

    wac_act_e          act;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;
    logic [ADDR_W-1:0] page_nxt;
    logic [ADDR_W-1:0] line_nxt;
    logic [ADDR_W-1:0] load_val;

    generate
        if (HI_W > 0) begin : g_hi
            // The top bits of the first address byte are discarded.
            logic unused_hi;
            always_comb unused_hi = ^load_word[LOAD_W-1:ADDR_W];
        end
    endgenerate

    // Purpose: take the address field out of the received bytes.
    always_comb load_val = load_word[ADDR_W-1:0];

    wac_prio u_prio (
        .load_strobe (load_strobe),
        .rd_step     (rd_step),
        .wr_step     (wr_step),
        .act         (act)
    );

    wac_page_inc #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_page (
        .a_in  (addr_q),
        .a_out (page_nxt)
    );

    wac_line_inc #(.ADDR_W(ADDR_W)) u_line (
        .a_in  (addr_q),
        .a_out (line_nxt)
    );

    // Purpose: choose the next address according to the resolved action.
    always_comb begin
        unique case (act)
            ACT_LOAD: addr_d = load_val;
            ACT_PAGE: addr_d = page_nxt;
            ACT_LINE: addr_d = line_nxt;
            default:  addr_d = addr_q;
        endcase
    end

    // Purpose: address register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign cur_addr = addr_q;
endmodule

// File: rtl/word_addr_ctr_chk.sv
// Module: word_addr_ctr_chk
// Property checker for word_addr_ctr, attached by bind. It observes the ports
// only.
module word_addr_ctr_chk #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_strobe,
    input logic [ADDR_W-1:0] load_lo,
    input logic              rd_step,
    input logic              wr_step,
    input logic [ADDR_W-1:0] cur_addr
);
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(1);
    localparam logic [PAGE_W-1:0] P1 = PAGE_W'(1);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> cur_addr == '0);

    // R2 R6
    load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |=> cur_addr == $past(load_lo));

    // R3 R7
    page_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_step && !load_strobe) |=>
            cur_addr[PAGE_W-1:0] == $past(cur_addr[PAGE_W-1:0]) + P1);

    // R3
    page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_step && !load_strobe) |=>
            cur_addr[ADDR_W-1:PAGE_W] == $past(cur_addr[ADDR_W-1:PAGE_W]));

    // R4
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && !wr_step && !load_strobe) |=> cur_addr == $past(cur_addr) + A1);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_step && !wr_step && !load_strobe) |=> $stable(cur_addr));
endmodule

bind word_addr_ctr word_addr_ctr_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_strobe (load_strobe),
    .load_lo     (load_word[ADDR_W-1:0]),
    .rd_step     (rd_step),
    .wr_step     (wr_step),
    .cur_addr    (cur_addr)
);

// File: tb/sim_word_addr_ctr.sv
// Scoreboard bench for word_addr_ctr. The driver computes each expected
// address from the requirements and queues it. The monitor compares one
// queued item after each rising edge.
module sim_word_addr_ctr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_strobe = 1'b0;
    logic [15:0] load_word = '0;
    logic        rd_step = 1'b0;
    logic        wr_step = 1'b0;
    logic [12:0] cur_addr;

    logic [12:0] exp_q[$];
    string       tag_q[$];
    logic [12:0] mdl = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    word_addr_ctr u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_strobe (load_strobe),
        .load_word   (load_word),
        .rd_step     (rd_step),
        .wr_step     (wr_step),
        .cur_addr    (cur_addr)
    );

    // Driver: apply one cycle of stimulus and queue the expected result.
    task automatic step(input bit rst, input bit ld, input logic [15:0] val,
                        input bit rd, input bit wr, input string tag);
        @(negedge clk);
        rst_n = !rst; load_strobe = ld; load_word = val;
        rd_step = rd; wr_step = wr;
        if (rst)     mdl = 13'd0;
        else if (ld) mdl = val[12:0];
        else if (wr) mdl = {mdl[12:5], 5'((mdl[4:0] + 5'd1))};
        else if (rd) mdl = 13'((mdl + 13'd1));
        exp_q.push_back(mdl);
        tag_q.push_back(tag);
    endtask

    // Monitor: after each rising edge, pop and compare one item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [12:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (cur_addr !== e) begin
                    n_fail++;
                    $display("FAIL %s: cur_addr=%h expected=%h", t, cur_addr, e);
                end
            end
        end
    end

    initial begin
        step(1, 0, 16'h0000, 0, 0, "R1 reset state");
        step(0, 1, 16'h1234, 0, 0, "R2 load");
        step(1, 1, 16'h0777, 1, 1, "R1 reset beats strobes");
        step(0, 1, 16'hFFFF, 0, 0, "R2 top bits ignored");
        step(0, 1, 16'hE003, 0, 0, "R2 top bits ignored low value");
        step(0, 1, 16'h003E, 0, 0, "R8 load before page step");
        step(0, 0, 16'h0000, 0, 1, "R3 offset 30 to 31");
        step(0, 0, 16'h0000, 0, 1, "R3 offset 31 wraps in page");
        step(0, 1, 16'h1FFF, 0, 0, "R2 load top");
        step(0, 0, 16'h0000, 0, 1, "R3 wrap at top page");
        step(0, 1, 16'h001F, 0, 0, "R2 load end of page");
        step(0, 0, 16'h0000, 1, 0, "R4 read crosses page");
        step(0, 1, 16'h1FFE, 0, 0, "R2 load near top");
        step(0, 0, 16'h0000, 1, 0, "R4 read to 8191");
        step(0, 0, 16'h0000, 1, 0, "R4 read wraps to 0");
        for (int i = 0; i < 4; i++) step(0, 0, 16'h0000, 0, 0, "R5 idle hold");
        step(0, 1, 16'h0A5A, 1, 0, "R6 load beats read");
        step(0, 1, 16'h15A5, 0, 1, "R6 load beats write");
        step(0, 1, 16'h005F, 1, 1, "R6 load beats both");
        step(0, 0, 16'h0000, 1, 1, "R7 both steps use page rule");
        step(0, 0, 16'h0000, 1, 0, "R4 read after R7");
        for (int i = 0; i < 40; i++) step(0, 0, 16'h0000, (i % 3) != 0, (i % 5) == 0, "R8 mixed steps");
        step(0, 0, 16'h0000, 0, 0, "R5 final hold");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog: cur_addr=%h expected=completion", cur_addr);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule